// File: doc/BRIEF.md
# Predicated Vector Immediate Broadcast Unit

This execution unit writes one small signed constant into every selected lane of a scalable vector. It takes a 32-bit instruction word, the current contents of the destination vector and the governing predicate. It decodes the lane width, a shift flag and an 8-bit signed constant from the word, then builds the new vector. Lanes whose predicate is set receive the constant, cut down to the lane width. The other lanes either keep their previous contents or are cleared, as the instruction selects.

The unit also reports two kinds of bad encoding. The first is a word whose fixed bits do not belong to this operation. The second is the one reserved combination of lane width and shift. In both cases the destination passes through unchanged. The vector length `VLEN` is a build-time parameter: a multiple of 128 from 128 to 2048. The predicate carries one bit per byte of the vector. Register-file reads and writes happen outside the unit.

Top module: `vec_imm_splat`

## Requirements
- R1: `out_valid` goes high one clock after a cycle with `in_valid` high and is low one clock after a cycle with `in_valid` low. A synchronous active-high `rst` clears `out_valid`, `out_undef`, `out_nomatch` and `out_vec`. The other outputs load only on cycles with `in_valid` high and hold otherwise.
- R2: `out_nomatch` is set when any fixed field of the word differs from its required value: bits [31:24] = 8'h05, bits [21:20] = 2'b01, bit 15 = 0. In that case `out_vec` equals the destination input.
- R3: A word with size field [23:22] = 0 and shift bit 13 = 1 sets `out_undef`. In that case `out_vec` equals the destination input.
- R4: The lane width is 8 << size bits, with size in bits [23:22]. The vector holds VLEN divided by that width lanes, and lane e occupies bits starting at e times the width.
- R5: The constant is imm8 (bits [12:5]) sign-extended. When bit 13 is 1 it is then shifted left by 8. An active lane receives the low lane-width bits of that value.
- R6: Lane e is active when predicate bit e*(width/8) is 1. The other predicate bits in the lane's byte group have no effect.
- R7: With merge bit 14 = 1, an inactive lane keeps the destination input's value.
- R8: With merge bit 14 = 0, an inactive lane is written as zero.
- R9: The register-number fields, bits [19:16] and [4:0], have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and word are valid this cycle |
| instr | input | 32 | Instruction word |
| dest_vec | input | VLEN | Current destination vector |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result valid |
| out_vec | output | VLEN | Result vector |
| out_undef | output | 1 | Reserved size/shift combination seen |
| out_nomatch | output | 1 | Fixed fields do not match this operation |

## Verification
All sixteen combinations of lane width, shift and merge are driven with several predicate patterns: all set, all clear, alternating bits, group-leading bits cleared with the rest set, and random values. The all-set and all-clear patterns separate constant placement from inactive-lane handling. The alternating and group-leading patterns show whether each lane reads the lowest predicate bit of its group and no other bit. The constants 8'h80, 8'h7f and zero test sign extension, truncation and the shifted-zero case. Words with single fixed bits flipped, idle cycles and a reset in the middle of traffic test the error flags, output holding and valid timing.

// File: rtl/splat_pkg.sv
package splat_pkg;

  // Decoded control fields of one broadcast instruction
  typedef struct packed {
    logic [1:0] size;     // log2 of lane width in bytes
    logic       merge;    // 1: inactive lanes keep old data
    logic       shift;    // 1: constant shifted left by 8
    logic [7:0] imm8;     // raw signed constant
    logic       undef;    // reserved size/shift pair
    logic       nomatch;  // fixed bits do not match
  } splat_ctl_t;

  // Fixed bits that identify the operation
  function automatic logic fixed_fields_ok(input logic [31:0] w);
    return (w[31:24] == 8'h05) && (w[21:20] == 2'b01) && !w[15];
  endfunction

  // Constant as a 64-bit two's complement value
  function automatic logic [63:0] splat_imm(input logic [7:0] imm8, input logic shift);
    logic [63:0] ext;
    ext = {{56{imm8[7]}}, imm8};
    return shift ? (ext << 8) : ext;
  endfunction

endpackage

// File: rtl/splat_decode.sv
module splat_decode
  import splat_pkg::*;
(
  input  logic [31:0] instr,
  output splat_ctl_t  ctl
);
  // Register-number fields are handled outside this unit
  logic unused_regnums;
  assign unused_regnums = ^{instr[19:16], instr[4:0]};

  always_comb begin
    ctl.size    = instr[23:22];
    ctl.merge   = instr[14];
    ctl.shift   = instr[13];
    ctl.imm8    = instr[12:5];
    ctl.undef   = (instr[23:22] == 2'd0) && instr[13];
    ctl.nomatch = !fixed_fields_ok(instr);
  end
endmodule

// File: rtl/splat_pred_expand.sv
module splat_pred_expand #(
  parameter int NBYTES = 32
) (
  input  logic [NBYTES-1:0] pred,
  input  logic [1:0]        size,
  output logic [NBYTES-1:0] byte_act
);
  // Each byte takes the predicate bit at the lowest byte of its lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int LEAD1 = b - (b % 2);
    localparam int LEAD2 = b - (b % 4);
    localparam int LEAD3 = b - (b % 8);
    assign byte_act[b] = (size == 2'd0) ? pred[b]     :
                         (size == 2'd1) ? pred[LEAD1] :
                         (size == 2'd2) ? pred[LEAD2] : pred[LEAD3];
  end
endmodule

// File: rtl/splat_lanes.sv
module splat_lanes #(
  parameter int NBYTES = 32
) (
  input  logic [8*NBYTES-1:0] dest,
  input  logic [NBYTES-1:0]   byte_act,
  input  logic [63:0]         imm64,
  input  logic [1:0]          size,
  input  logic                merge,
  input  logic                wr_en,
  output logic [8*NBYTES-1:0] res
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int POS1 = b % 2;
    localparam int POS2 = b % 4;
    localparam int POS3 = b % 8;
    logic [7:0] imm_byte;
    logic [7:0] idle_byte;
    // Which byte of the constant lands here depends on lane width
    assign imm_byte  = (size == 2'd0) ? imm64[7:0]         :
                       (size == 2'd1) ? imm64[8*POS1 +: 8] :
                       (size == 2'd2) ? imm64[8*POS2 +: 8] : imm64[8*POS3 +: 8];
    assign idle_byte = merge ? dest[8*b +: 8] : 8'h00;
    assign res[8*b +: 8] = !wr_en      ? dest[8*b +: 8] :
                           byte_act[b] ? imm_byte       : idle_byte;
  end
endmodule

// File: rtl/vec_imm_splat.sv
module vec_imm_splat
  import splat_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VLEN-1:0]   dest_vec,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   out_vec,
  output logic              out_undef,
  output logic              out_nomatch
);
  localparam int NBYTES = VLEN / 8;

  if ((VLEN % 128) != 0 || VLEN < 128 || VLEN > 2048) begin : g_bad_vlen
    $error("VLEN must be a multiple of 128 within 128..2048");
  end

  splat_ctl_t        ctl;
  logic [63:0]       imm64;
  logic [NBYTES-1:0] byte_act;
  logic              dec_fault;
  logic              wr_en;
  logic [VLEN-1:0]   next_vec;

  splat_decode u_decode (
    .instr (instr),
    .ctl   (ctl)
  );

  assign imm64     = splat_imm(ctl.imm8, ctl.shift);
  assign dec_fault = ctl.undef | ctl.nomatch;
  assign wr_en     = !dec_fault;

  splat_pred_expand #(.NBYTES(NBYTES)) u_pred (
    .pred     (pred),
    .size     (ctl.size),
    .byte_act (byte_act)
  );

  splat_lanes #(.NBYTES(NBYTES)) u_lanes (
    .dest     (dest_vec),
    .byte_act (byte_act),
    .imm64    (imm64),
    .size     (ctl.size),
    .merge    (ctl.merge),
    .wr_en    (wr_en),
    .res      (next_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_vec     <= '0;
      out_undef   <= 1'b0;
      out_nomatch <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec     <= next_vec;
        out_undef   <= ctl.undef;
        out_nomatch <= ctl.nomatch;
      end
    end
  end
endmodule

// File: rtl/splat_chk.sv
module splat_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [VLEN-1:0]   dest_vec,
  input logic [VLEN/8-1:0] pred,
  input logic              out_valid,
  input logic [VLEN-1:0]   out_vec,
  input logic              out_undef,
  input logic              out_nomatch
);
  logic unused_regnums;
  assign unused_regnums = ^{instr[19:16], instr[4:0]};

  logic fields_ok;
  logic good_word;
  assign fields_ok = (instr[31:24] == 8'h05) && (instr[21:20] == 2'b01) && !instr[15];
  assign good_word = fields_ok && !((instr[23:22] == 2'd0) && instr[13]);

  // R1
  rst_clears_chk: assert property (@(posedge clk) rst |=> !out_valid && !out_undef && !out_nomatch);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec) && $stable(out_undef) && $stable(out_nomatch));

  // R2
  nomatch_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_nomatch == !$past(fields_ok));

  // R3
  undef_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr[23:22] == 2'd0 && instr[13] |=> out_undef && out_vec == $past(dest_vec));

  // R5
  byte_imm_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && good_word && instr[23:22] == 2'd0 && pred[0] |=> out_vec[7:0] == $past(instr[12:5]));

  // R7
  merge_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && good_word && instr[14] && pred == '0 |=> out_vec == $past(dest_vec));

  // R8
  zero_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && good_word && !instr[14] && !pred[0] |=> out_vec[7:0] == 8'h00);
endmodule

bind vec_imm_splat splat_chk #(.VLEN(VLEN)) u_splat_chk (.*);

// File: tb/vec_imm_splat_bench.sv
module vec_imm_splat_bench;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VL-1:0] dest_vec = '0;
  logic [PL-1:0] pred = '0;
  logic          out_valid;
  logic [VL-1:0] out_vec;
  logic          out_undef;
  logic          out_nomatch;

  int checks = 0;
  int errors = 0;

  // Expected outputs after the next clock edge
  logic          exp_valid = 1'b0;
  logic [VL-1:0] exp_vec = '0;
  logic          exp_undef = 1'b0;
  logic          exp_nomatch = 1'b0;
  string         exp_tag = "R1";
  bit            chk_on = 1'b0;

  always #5 clk = ~clk;

  vec_imm_splat #(.VLEN(VL)) u_vec_imm_splat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .dest_vec(dest_vec), .pred(pred), .out_valid(out_valid),
    .out_vec(out_vec), .out_undef(out_undef), .out_nomatch(out_nomatch)
  );

  function automatic logic [31:0] mk(input int sz, input int sh, input int m,
                                     input logic [7:0] imm, input logic [3:0] pg, input logic [4:0] zd);
    logic [31:0] w;
    w = {8'h05, 2'(sz), 2'b01, pg, 1'b0, 1'(m), 1'(sh), imm, zd};
    return w;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Lane-by-lane model of the requirements (R4..R8)
  function automatic logic [VL-1:0] model(input logic [31:0] w, input logic [VL-1:0] d,
                                           input logic [PL-1:0] p);
    logic [VL-1:0] r;
    int esize;
    int lanes;
    longint val;
    esize = 8 << w[23:22];
    lanes = VL / esize;
    val = longint'($signed(w[12:5]));
    if (w[13]) val = val * 256;
    for (int e = 0; e < lanes; e++) begin
      bit act;
      act = p[e * (esize / 8)];
      for (int k = 0; k < esize; k++) begin
        if (act) r[e*esize + k] = val[k];
        else if (w[14]) r[e*esize + k] = d[e*esize + k];
        else r[e*esize + k] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, exp_valid);
    end
    checks++;
    if (out_undef !== exp_undef) begin
      errors++;
      $display("FAIL R3 out_undef actual %0b expected %0b", out_undef, exp_undef);
    end
    checks++;
    if (out_nomatch !== exp_nomatch) begin
      errors++;
      $display("FAIL R2 out_nomatch actual %0b expected %0b", out_nomatch, exp_nomatch);
    end
    checks++;
    if (out_vec !== exp_vec) begin
      errors++;
      $display("FAIL %s out_vec actual %h expected %h", exp_tag, out_vec, exp_vec);
    end
  endtask

  task automatic cycle(input logic r, input logic v, input logic [31:0] w,
                       input logic [VL-1:0] d, input logic [PL-1:0] p);
    bit nm;
    bit ud;
    @(negedge clk);
    if (chk_on) compare();
    rst = r; in_valid = v; instr = w; dest_vec = d; pred = p;
    chk_on = 1'b1;
    if (r) begin
      exp_valid = 1'b0; exp_vec = '0; exp_undef = 1'b0; exp_nomatch = 1'b0; exp_tag = "R1";
    end else begin
      exp_valid = v;
      if (v) begin
        nm = (w[31:24] != 8'h05) || (w[21:20] != 2'b01) || w[15];
        ud = (w[23:22] == 2'd0) && w[13];
        exp_nomatch = nm;
        exp_undef = ud;
        if (nm || ud) begin
          exp_vec = d;
          exp_tag = nm ? "R2" : "R3";
        end else begin
          exp_vec = model(w, d, p);
          exp_tag = w[14] ? "R4 R5 R6 R7" : "R4 R5 R6 R8";
        end
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R1 watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PL-1:0] lead_clr;
    lead_clr = '1;
    for (int i = 0; i < PL; i += 8) lead_clr[i] = 1'b0;

    // R1: reset state
    repeat (3) cycle(1'b1, 1'b0, '0, '0, '0);
    cycle(1'b0, 1'b0, '0, '0, '0);

    // R4 R5 R6 R7 R8 R3 R9: every size/shift/merge combination, random Zd/Pg
    for (int sz = 0; sz < 4; sz++)
      for (int sh = 0; sh < 2; sh++)
        for (int m = 0; m < 2; m++) begin
          for (int it = 0; it < 6; it++) begin
            logic [7:0] imm;
            logic [PL-1:0] p;
            imm = (it == 0) ? 8'h80 : (it == 1) ? 8'h7f : (it == 2) ? 8'h00 : 8'($urandom);
            case (it)
              0: p = '1;
              1: p = '0;
              2: p = {(PL/2){2'b01}};
              3: p = lead_clr;
              default: p = PL'($urandom);
            endcase
            cycle(1'b0, 1'b1, mk(sz, sh, m, imm, 4'($urandom), 5'($urandom)), rnd_vec(), p);
          end
          // R1: idle cycle holds the result
          cycle(1'b0, 1'b0, rnd_vec()[31:0], rnd_vec(), PL'($urandom));
        end

    // R9: same operation with different register numbers gives the same result
    begin
      logic [VL-1:0] d;
      d = rnd_vec();
      cycle(1'b0, 1'b1, mk(2, 1, 1, 8'hc3, 4'h0, 5'h00), d, {(PL/4){4'b0101}});
      cycle(1'b0, 1'b1, mk(2, 1, 1, 8'hc3, 4'hf, 5'h1f), d, {(PL/4){4'b0101}});
    end

    // R2: single fixed-bit faults
    cycle(1'b0, 1'b1, mk(1, 0, 0, 8'h11, 4'h2, 5'h3) ^ 32'h8000_0000, rnd_vec(), '1);
    cycle(1'b0, 1'b1, mk(1, 0, 0, 8'h11, 4'h2, 5'h3) ^ 32'h0010_0000, rnd_vec(), '1);
    cycle(1'b0, 1'b1, mk(1, 0, 0, 8'h11, 4'h2, 5'h3) | 32'h0000_8000, rnd_vec(), '1);
    // R2 R3: both faults at once
    cycle(1'b0, 1'b1, mk(0, 1, 1, 8'h01, 4'h0, 5'h0) ^ 32'h0100_0000, rnd_vec(), '1);

    // R1: reset during traffic
    cycle(1'b0, 1'b1, mk(3, 0, 1, 8'hfe, 4'h1, 5'h1), rnd_vec(), '1);
    cycle(1'b1, 1'b1, mk(3, 0, 1, 8'hfe, 4'h1, 5'h1), rnd_vec(), '1);
    cycle(1'b0, 1'b1, mk(0, 0, 0, 8'h5a, 4'h1, 5'h1), rnd_vec(), PL'($urandom));
    cycle(1'b0, 1'b0, '0, '0, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule